// File: doc/BRIEF.md
# AHB Read-Side Register Slave with Completion-Gated Side Effects

This block is the read side of a small AHB-Lite peripheral slave. It samples the address phase, keeps the selected register index, and in the following data phase drives the read-data bus from that captured location. The register window holds four words: a control word that software can also write, a status word that is read-only, an interrupt word that clears when read, and a receive-data word whose read consumes one entry from an internal FIFO.

The receive path is modelled as a slow source. A read of it holds HREADYOUT low for a fixed number of wait cycles, set by a parameter, and then presents the head entry. A read of an address outside the window gets the two-cycle ERROR response.

The clear of the interrupt word and the pop of the FIFO fire only in the cycle that completes a legal read. That cycle is the one where the registered select and read direction are set, HREADYOUT is high and no error is signalled. A waited read therefore consumes exactly one entry, and idle, busy, unselected or erroneous cycles change nothing.

Top module: `ahb_rd_slave`

## Requirements
- R1: An address phase is taken only when hsel is high, htrans is NONSEQ (2'b10) or SEQ (2'b11) and hready is high. IDLE (2'b00), BUSY (2'b01) and unselected cycles get a zero-wait OKAY response and trigger no clear or pop.
- R2: hrdata is zero in every cycle that is not the data phase of a legal read, including write data phases, error cycles and idle cycles.
- R3: Word offsets decode as follows: 0x00 is control, 0x04 is status, 0x08 is interrupt and 0x0C is receive data. The status word carries empty in bit 0, full in bit 1 and the FIFO entry count from bit 2 upward. Reads of control, status and interrupt complete with no wait cycle.
- R4: A read at any byte address of 0x10 or above gives HRESP=1 with HREADYOUT=0 in the first cycle and HRESP=1 with HREADYOUT=1 in the second, with hrdata zero. It changes no register and no FIFO state. HRESP is 0 in all other cycles.
- R5: A read of the interrupt word returns the value held before the read and clears that word in its completing cycle only.
- R6: A read of the receive-data word holds HREADYOUT low for RX_LAT cycles, then presents the oldest FIFO entry with OKAY and removes exactly one entry.
- R7: A read of the receive-data word while the FIFO is empty returns zero and leaves the FIFO count unchanged.
- R8: A bit set on irqSet in the same cycle as an interrupt-word clear is kept, so the event is not lost.
- R9: After reset, HREADYOUT is 1, HRESP is 0, hrdata is 0, control and interrupt read 0, and status reads 1 (empty).
- R10: A write to offset 0x00 loads control from hwdata in its data phase with a zero-wait OKAY response. Writes to other offsets change nothing. A push into a full FIFO is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select from the address decoder |
| haddr | input | ADDR_W | Byte address of the address phase |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | Direction, 1 for write |
| hready | input | 1 | Bus-wide ready, previous transfer complete |
| hwdata | input | DATA_W | Write data in the data phase |
| irqSet | input | IRQ_W | Per-bit event set of the interrupt word |
| rxPush | input | 1 | Push strobe into the receive FIFO |
| rxPushData | input | DATA_W | Data pushed into the receive FIFO |
| hrdata | output | DATA_W | Read data, zero outside legal read data phases |
| hreadyout | output | 1 | Transfer completion from this slave |
| hresp | output | 1 | Response, 1 for ERROR |

## Verification
Reads are issued with the FIFO empty, partly filled and full, so the value presented and the count left behind show whether one pop per read happened, or none, or several across the wait cycles. Read-to-clear is run plainly, then with an event set in the completing cycle, then after BUSY and unselected cycles aimed at the same word; these separate a correct clear from a missing clear, an early clear and a clear that overrides the set. Reads outside the window are checked cycle by cycle for the two-phase response shape and are followed by status and interrupt reads that show nothing moved. Writes to control and to a read-only word show which offsets accept data.

// File: rtl/ahb_rd_pkg.sv
package ahb_rd_pkg;

  // Data-phase state of the read controller
  typedef enum logic [2:0] {
    ST_IDLE,     // no read data phase, ready high
    ST_WAIT,     // slow source not ready, ready low
    ST_PRESENT,  // completing legal read cycle
    ST_ERR1,     // error, first cycle (ready low)
    ST_ERR2      // error, second cycle (ready high)
  } rd_state_e;

  // Word index inside the register window
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_IRQ  = 2'd2,
    SEL_RX   = 2'd3
  } reg_sel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic ctrlWr;   // load control word from hwdata
    logic irqClr;   // clear interrupt word on completion
    logic rxPop;    // consume one receive entry on completion
    logic drvData;  // legal read data phase: drive the selected word
  } strobe_t;

endpackage

// File: rtl/ahb_rd_ctrl.sv
module ahb_rd_ctrl
  import ahb_rd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int RX_LAT = 1
) (
  input  logic              hclk,
  input  logic              hresetn,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic              hready,
  output reg_sel_e          regSel,
  output strobe_t           strb,
  output logic              hreadyout,
  output logic              hresp
);

  localparam int LAT_W = (RX_LAT > 1) ? $clog2(RX_LAT) : 1;
  localparam logic [LAT_W-1:0] LAT_LOAD = LAT_W'((RX_LAT > 0) ? RX_LAT - 1 : 0);
  localparam bit HAS_WAIT = (RX_LAT > 0);

  rd_state_e        state, stNext;
  logic [LAT_W-1:0] waitCnt, cntNext;
  logic             selQ, writeQ, legalQ;

  // Address-phase decode
  logic     accept;
  logic     legalAddr;
  reg_sel_e addrSel;
  logic     unusedBits;

  assign accept     = hsel && htrans[1] && hready;
  assign legalAddr  = (haddr[ADDR_W-1:4] == '0);
  assign addrSel    = reg_sel_e'(haddr[3:2]);
  assign unusedBits = ^{htrans[0], haddr[1:0]};

  // Capture registers, loaded only while the bus is ready
  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      selQ   <= 1'b0;
      writeQ <= 1'b0;
      legalQ <= 1'b0;
      regSel <= SEL_CTRL;
    end else if (hready) begin
      selQ   <= accept;
      writeQ <= hwrite;
      legalQ <= legalAddr;
      regSel <= addrSel;
    end
  end

  // Next-state logic
  always_comb begin
    stNext  = state;
    cntNext = waitCnt;
    unique case (state)
      ST_WAIT: begin
        if (waitCnt == '0) stNext = ST_PRESENT;
        else               cntNext = waitCnt - LAT_W'(1);
      end
      ST_ERR1: stNext = ST_ERR2;
      default: begin
        // IDLE, PRESENT and ERR2 are completion cycles that can take a new phase
        stNext = ST_IDLE;
        if (accept && !hwrite) begin
          if (!legalAddr) begin
            stNext = ST_ERR1;
          end else if (HAS_WAIT && addrSel == SEL_RX) begin
            stNext  = ST_WAIT;
            cntNext = LAT_LOAD;
          end else begin
            stNext = ST_PRESENT;
          end
        end
      end
    endcase
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state   <= stNext;
      waitCnt <= cntNext;
    end
  end

  // Bus response
  assign hreadyout = !(state == ST_WAIT || state == ST_ERR1);
  assign hresp     = (state == ST_ERR1) || (state == ST_ERR2);

  // Side effects: registered select, read, completion, no error
  logic readDone;
  assign readDone = selQ && !writeQ && hreadyout && !hresp;

  always_comb begin
    strb.ctrlWr  = selQ && writeQ && legalQ && (regSel == SEL_CTRL);
    strb.irqClr  = readDone && (regSel == SEL_IRQ);
    strb.rxPop   = readDone && (regSel == SEL_RX);
    strb.drvData = selQ && !writeQ && (state == ST_WAIT || state == ST_PRESENT);
  end

endmodule

// File: rtl/ahb_rd_dpath.sv
module ahb_rd_dpath
  import ahb_rd_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int IRQ_W      = 8
) (
  input  logic              hclk,
  input  logic              hresetn,
  input  strobe_t           strb,
  input  reg_sel_e          regSel,
  input  logic [DATA_W-1:0] hwdata,
  input  logic [IRQ_W-1:0]  irqSet,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxPushData,
  output logic [DATA_W-1:0] hrdata
);

  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(FIFO_DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FIFO_DEPTH);

  // Control word
  logic [DATA_W-1:0] ctrlReg;
  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn)         ctrlReg <= '0;
    else if (strb.ctrlWr) ctrlReg <= hwdata;
  end

  // Interrupt word: per-bit set has priority over the read clear
  logic [IRQ_W-1:0] irqReg;
  for (genvar b = 0; b < IRQ_W; b++) begin : g_irq
    always_ff @(posedge hclk or negedge hresetn) begin
      if (!hresetn)         irqReg[b] <= 1'b0;
      else if (irqSet[b])   irqReg[b] <= 1'b1;
      else if (strb.irqClr) irqReg[b] <= 1'b0;
    end
  end

  // Receive FIFO (behavioural storage)
  logic [DATA_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              empty, full, doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CNT_FULL);
  assign doPush = rxPush && !full;
  assign doPop  = strb.rxPop && !empty;

  always_ff @(posedge hclk) begin
    if (doPush) mem[wrPtr] <= rxPushData;
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + PTR_W'(1);
      if (doPop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + PTR_W'(1);
      unique case ({doPush, doPop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // Read sources
  logic [DATA_W-1:0] statusWord, rxWord, srcWord;
  assign statusWord = DATA_W'({count, full, empty});
  assign rxWord     = empty ? '0 : mem[rdPtr];

  always_comb begin
    unique case (regSel)
      SEL_CTRL: srcWord = ctrlReg;
      SEL_STAT: srcWord = statusWord;
      SEL_IRQ:  srcWord = DATA_W'(irqReg);
      default:  srcWord = rxWord;
    endcase
  end

  // Zero outside a legal read data phase for the AND-OR return mux
  assign hrdata = strb.drvData ? srcWord : '0;

endmodule

// File: rtl/ahb_rd_slave.sv
module ahb_rd_slave
  import ahb_rd_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int IRQ_W      = 8,
  parameter int RX_LAT     = 1
) (
  input  logic              hclk,
  input  logic              hresetn,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic              hready,
  input  logic [DATA_W-1:0] hwdata,
  input  logic [IRQ_W-1:0]  irqSet,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxPushData,
  output logic [DATA_W-1:0] hrdata,
  output logic              hreadyout,
  output logic              hresp
);

  strobe_t  strb;
  reg_sel_e regSel;

  ahb_rd_ctrl #(
    .ADDR_W (ADDR_W),
    .RX_LAT (RX_LAT)
  ) u_ctrl (
    .hclk      (hclk),
    .hresetn   (hresetn),
    .hsel      (hsel),
    .haddr     (haddr),
    .htrans    (htrans),
    .hwrite    (hwrite),
    .hready    (hready),
    .regSel    (regSel),
    .strb      (strb),
    .hreadyout (hreadyout),
    .hresp     (hresp)
  );

  ahb_rd_dpath #(
    .DATA_W     (DATA_W),
    .FIFO_DEPTH (FIFO_DEPTH),
    .IRQ_W      (IRQ_W)
  ) u_dpath (
    .hclk       (hclk),
    .hresetn    (hresetn),
    .strb       (strb),
    .regSel     (regSel),
    .hwdata     (hwdata),
    .irqSet     (irqSet),
    .rxPush     (rxPush),
    .rxPushData (rxPushData),
    .hrdata     (hrdata)
  );

endmodule

// File: rtl/ahb_rd_slave_chk.sv
module ahb_rd_slave_chk #(
  parameter int DATA_W = 32
) (
  input logic              hclk,
  input logic              hresetn,
  input logic              hsel,
  input logic [1:0]        htrans,
  input logic              hready,
  input logic              hreadyout,
  input logic              hresp,
  input logic [DATA_W-1:0] hrdata,
  input logic              irqClr,
  input logic              rxPop
);

  // R4: first error cycle is followed by the completing error cycle
  a_r4_err_second: assert property (@(posedge hclk) disable iff (!hresetn)
    (hresp && !hreadyout) |=> (hresp && hreadyout));

  // R4: an error response always opens with ready low
  a_r4_err_opens_low: assert property (@(posedge hclk) disable iff (!hresetn)
    $rose(hresp) |-> !hreadyout);

  // R2 / R4: no data during an error
  a_r2_err_no_data: assert property (@(posedge hclk) disable iff (!hresetn)
    hresp |-> (hrdata == '0));

  // R5: clear only in a completing OKAY cycle
  a_r5_clr_on_done: assert property (@(posedge hclk) disable iff (!hresetn)
    irqClr |-> (hreadyout && !hresp));

  // R6: pop only in a completing OKAY cycle
  a_r6_pop_on_done: assert property (@(posedge hclk) disable iff (!hresetn)
    rxPop |-> (hreadyout && !hresp));

  // R1: idle or busy transfer gets zero-wait OKAY
  a_r1_idle_okay: assert property (@(posedge hclk) disable iff (!hresetn)
    (hsel && hready && !htrans[1]) |=> (hreadyout && !hresp));

  // R2: no select in a ready cycle means zero read data next
  a_r2_unsel_zero: assert property (@(posedge hclk) disable iff (!hresetn)
    (hready && !hsel) |=> (hrdata == '0));

endmodule

bind ahb_rd_slave ahb_rd_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .hclk      (hclk),
  .hresetn   (hresetn),
  .hsel      (hsel),
  .htrans    (htrans),
  .hready    (hready),
  .hreadyout (hreadyout),
  .hresp     (hresp),
  .hrdata    (hrdata),
  .irqClr    (strb.irqClr),
  .rxPop     (strb.rxPop)
);

// File: tb/ahb_rd_slave_bench.sv
`timescale 1ns/1ps
module ahb_rd_slave_bench;

  localparam int LAT   = 2;
  localparam int DEPTH = 4;

  logic        hclk = 1'b0;
  logic        hresetn = 1'b0;
  logic        hsel = 1'b0;
  logic [7:0]  haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic        hwrite = 1'b0;
  logic        hready;
  logic [31:0] hwdata = '0;
  logic [7:0]  irqSet = '0;
  logic        rxPush = 1'b0;
  logic [31:0] rxPushData = '0;
  logic [31:0] hrdata;
  logic        hreadyout;
  logic        hresp;

  assign hready = hreadyout;

  always #4 hclk = ~hclk;

  ahb_rd_slave #(
    .ADDR_W(8), .DATA_W(32), .FIFO_DEPTH(DEPTH), .IRQ_W(8), .RX_LAT(LAT)
  ) u_ahb_rd_slave (
    .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr),
    .htrans(htrans), .hwrite(hwrite), .hready(hready), .hwdata(hwdata),
    .irqSet(irqSet), .rxPush(rxPush), .rxPushData(rxPushData),
    .hrdata(hrdata), .hreadyout(hreadyout), .hresp(hresp)
  );

  // Reference model state
  logic [31:0] ctrlM = '0;
  logic [7:0]  irqM  = '0;
  logic [31:0] fifoM [$];

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] statusM();
    int n = fifoM.size();
    return (32'(n) << 2) | (32'(n == DEPTH) << 1) | 32'(n == 0);
  endfunction

  // Idle cycle: zero-wait OKAY, no data
  task automatic idleChk(input string tag);
    chk({tag, " ready"}, 32'(hreadyout), 32'd1);
    chk({tag, " resp"},  32'(hresp),     32'd0);
    chk({tag, " data"},  hrdata,         32'd0);
  endtask

  task automatic pushRx(input logic [31:0] d);
    rxPush = 1'b1; rxPushData = d;
    @(negedge hclk);
    rxPush = 1'b0;
    if (fifoM.size() < DEPTH) fifoM.push_back(d);
  endtask

  task automatic setIrq(input logic [7:0] m);
    irqSet = m;
    @(negedge hclk);
    irqSet = '0;
    irqM = irqM | m;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    hsel = 1'b1; htrans = 2'b10; haddr = a; hwrite = 1'b1;
    @(negedge hclk);
    hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hwdata = d;
    idleChk({tag, " write phase"});
    @(negedge hclk);
    if (a == 8'h00) ctrlM = d;
  endtask

  // Non-pipelined read with optional event set in the completing cycle
  task automatic rd(input logic [7:0] a, input logic [7:0] setMask, input string tag);
    logic [31:0] expD;
    int waits = 0;
    int expW;
    int idx = int'(a >> 2);
    if (a >= 8'h10) begin
      hsel = 1'b1; htrans = 2'b10; haddr = a; hwrite = 1'b0;
      @(negedge hclk);
      hsel = 1'b0; htrans = 2'b00;
      chk({tag, " err1 ready"}, 32'(hreadyout), 32'd0);
      chk({tag, " err1 resp"},  32'(hresp),     32'd1);
      chk({tag, " err1 data"},  hrdata,         32'd0);
      @(negedge hclk);
      chk({tag, " err2 ready"}, 32'(hreadyout), 32'd1);
      chk({tag, " err2 resp"},  32'(hresp),     32'd1);
      chk({tag, " err2 data"},  hrdata,         32'd0);
      @(negedge hclk);
      chk({tag, " after err resp"}, 32'(hresp), 32'd0);
      return;
    end
    case (idx)
      0:       expD = ctrlM;
      1:       expD = statusM();
      2:       expD = 32'(irqM);
      default: expD = (fifoM.size() > 0) ? fifoM[0] : 32'd0;
    endcase
    expW = (idx == 3) ? LAT : 0;
    hsel = 1'b1; htrans = 2'b10; haddr = a; hwrite = 1'b0;
    @(negedge hclk);
    hsel = 1'b0; htrans = 2'b00;
    while (!hreadyout && waits < 20) begin
      chk({tag, " wait resp"}, 32'(hresp), 32'd0);
      waits++;
      @(negedge hclk);
    end
    chk({tag, " wait count"}, 32'(waits), 32'(expW));
    chk({tag, " resp"},       32'(hresp), 32'd0);
    chk({tag, " data"},       hrdata,     expD);
    irqSet = setMask;
    @(negedge hclk);
    irqSet = '0;
    if (idx == 2) irqM = setMask;          // clear, set wins
    else irqM = irqM | setMask;
    if (idx == 3 && fifoM.size() > 0) void'(fifoM.pop_front());
  endtask

  // Non-capturing transfer (busy or unselected)
  task automatic noCap(input logic s, input logic [1:0] t, input logic [7:0] a, input string tag);
    hsel = s; htrans = t; haddr = a; hwrite = 1'b0;
    @(negedge hclk);
    hsel = 1'b0; htrans = 2'b00;
    idleChk(tag);
    @(negedge hclk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge hclk);
    errs++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge hclk);
    hresetn = 1'b1;
    @(negedge hclk);

    // R9 reset state
    idleChk("R9 reset");
    rd(8'h00, 8'h00, "R9 ctrl reset");
    rd(8'h04, 8'h00, "R9 status reset");
    rd(8'h08, 8'h00, "R9 irq reset");

    // R10 control write, read-only write ignored
    wr(8'h00, 32'hA5A5_1234, "R10 ctrl");
    rd(8'h00, 8'h00, "R10 ctrl readback");
    wr(8'h04, 32'hFFFF_FFFF, "R10 status write");
    rd(8'h04, 8'h00, "R10 status unchanged");

    // R7 empty receive read
    rd(8'h0C, 8'h00, "R7 empty rx");
    rd(8'h04, 8'h00, "R7 count unchanged");

    // R6 / R3 partly filled
    pushRx(32'h11); pushRx(32'h22); pushRx(32'h33);
    rd(8'h04, 8'h00, "R3 status three");
    rd(8'h0C, 8'h00, "R6 rx first");
    rd(8'h04, 8'h00, "R6 single pop");
    rd(8'h0C, 8'h00, "R6 rx second");
    rd(8'h0C, 8'h00, "R6 rx third");
    rd(8'h04, 8'h00, "R6 drained");

    // R10 / R3 full FIFO, overflow dropped
    for (int i = 0; i < DEPTH + 1; i++) pushRx(32'h100 + 32'(i));
    rd(8'h04, 8'h00, "R10 full status");
    for (int i = 0; i < DEPTH; i++) rd(8'h0C, 8'h00, "R6 full drain");
    rd(8'h0C, 8'h00, "R7 empty after drain");

    // R5 read-to-clear
    setIrq(8'h05);
    rd(8'h08, 8'h00, "R5 pre-clear value");
    rd(8'h08, 8'h00, "R5 cleared");

    // R1 busy and unselected leave side effects alone
    setIrq(8'h03);
    noCap(1'b1, 2'b01, 8'h08, "R1 busy irq");
    noCap(1'b0, 2'b10, 8'h08, "R1 unselected irq");
    noCap(1'b1, 2'b00, 8'h08, "R1 idle irq");
    rd(8'h08, 8'h00, "R1 irq kept");
    pushRx(32'h77);
    noCap(1'b1, 2'b01, 8'h0C, "R1 busy rx");
    noCap(1'b0, 2'b11, 8'h0C, "R1 unselected rx");
    rd(8'h04, 8'h00, "R1 rx kept");

    // R4 illegal reads, no side effect
    setIrq(8'h01);
    rd(8'h10, 8'h00, "R4 reserved 0x10");
    rd(8'hFC, 8'h00, "R4 reserved 0xFC");
    rd(8'h04, 8'h00, "R4 status untouched");
    rd(8'h08, 8'h00, "R4 irq untouched");

    // R8 set during clear wins
    setIrq(8'h0C);
    rd(8'h08, 8'h02, "R8 clear with set");
    rd(8'h08, 8'h00, "R8 set kept");
    rd(8'h08, 8'h00, "R8 then cleared");

    // R6 remaining entry after everything
    rd(8'h0C, 8'h00, "R6 last entry");
    rd(8'h04, 8'h00, "R6 final status");
    idleChk("R2 final idle");

    finishRun();
  end

endmodule